// File: doc/BRIEF.md
# Serial ADC Result Output Shifter

This block is the digital read-out path of a multi-channel converter. A conversion-complete strobe delivers a 16-bit straight-binary result and the 3-bit number of the channel it came from. The pair waits in a holding register. It moves into the shift register only when frame select next falls, so a host that opens its frame before the strobe reads the previous result, and one that opens it after reads the new result.

Within a frame the output presents the MSB at once. It advances one bit per serial clock falling edge and the host samples on rising edges. An optional 3-bit channel tag may follow the LSB. All later bits are zeros. When the chain bit is set, the later bits instead repeat the chain input, so several devices can be cascaded on one data line. The output is enabled only while a frame is open. The first frame after reset sends ones in place of a result. All inputs are sampled by the system clock `clk_i`. Frame select and the serial clock must each hold a level for at least one system clock.

Top module: `adc_result_serializer`

## Requirements
- R1: A high `eoc_i` stores `result_i` and `chan_i` in the holding register at that clock edge. The bits on `sdo_o` do not change until the next falling edge of `fs_ni`.
- R2: A falling edge of `fs_ni` moves the held result into the shift register. If `eoc_i` is high in the same clock cycle as that falling edge, the frame carries the previously held result and the new one waits for the next frame.
- R3: Data bits leave MSB first, result bit 15 first and bit 0 last, in straight binary (FFFF full scale, 8000 midscale, 0000 zero).
- R4: With `tag_en_i` = 1 at frame start, the three bits after the LSB are the channel number, bit 2 first. Channel n is sent as the 3-bit binary value n, so a tagged read takes 19 serial clocks.
- R5: With `chain_en_i` = 0, every bit after the data (and tag) is 0 until `fs_ni` rises.
- R6: `sdo_oe_o` goes high one clock after `fs_ni` is sampled low following a high level. It goes low one clock after `fs_ni` is sampled high. `sdo_o` is 0 whenever `sdo_oe_o` is 0, and both are 0 during reset.
- R7: In the first frame after reset, every data bit (and every tag bit, if the tag is on) is 1. The held result is not consumed by that frame.
- R8: A frame with fewer serial clocks than data bits outputs only that many leading MSBs. The next frame starts again at the MSB of the held result.
- R9: With `chain_en_i` = 1 at frame start, bit position L+k (L = 16, or 19 with the tag) carries the `chain_i` value sampled at the serial clock rising edge of position k, in place of 0.
- R10: `sdo_o` shows the MSB in the same clock cycle that `sdo_oe_o` first goes high. It moves to the next bit one clock after a serial clock falling edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; samples all inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eoc_i | input | 1 | Conversion-complete strobe |
| result_i | input | 16 | Conversion result, straight binary |
| chan_i | input | 3 | Channel that produced the result |
| tag_en_i | input | 1 | Append channel tag after LSB |
| chain_en_i | input | 1 | Use chain_i as trailing data (cascade) |
| fs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock from host |
| chain_i | input | 1 | Serial data from upstream device |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low = high impedance) |

## Verification
The conversion strobe and the frame-select fall can land in the same system clock cycle. In that cycle a stored result is both being replaced and being loaded. The bench provokes this by driving `eoc_i` high on the same edge it drives `fs_ni` low. It expects the frame to carry the earlier result and the following frame to carry the new one. A strobe placed in the middle of an open frame is also checked to leave the bits already in flight untouched.

// File: rtl/adc_sdo_pkg.sv
package adc_sdo_pkg;
  parameter int DATA_W = 16;
  parameter int TAG_W  = 3;

  typedef struct packed {
    logic fs_fall;
    logic sclk_rise;
    logic sclk_fall;
  } edges_t;
endpackage

// File: rtl/sdo_edge_det.sv
module sdo_edge_det (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fs_ni,
  input  logic                sclk_i,
  output adc_sdo_pkg::edges_t edg_o
);
  logic fs_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      fs_q   <= fs_ni;
      sclk_q <= sclk_i;
    end
  end

  assign edg_o.fs_fall   = fs_q & ~fs_ni;
  assign edg_o.sclk_rise = ~sclk_q & sclk_i;
  assign edg_o.sclk_fall = sclk_q & ~sclk_i;

  assert_fall_after_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edg_o.fs_fall |=> !fs_q);
endmodule

// File: rtl/sdo_hold_reg.sv
module sdo_hold_reg #(
  parameter int DATA_W = adc_sdo_pkg::DATA_W,
  parameter int TAG_W  = adc_sdo_pkg::TAG_W,
  localparam int SH_W  = DATA_W + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [TAG_W-1:0]  chan_i,
  input  logic              fs_fall_i,
  input  logic              tag_en_i,
  output logic [SH_W-1:0]   load_word_o,
  output logic              first_o
);
  logic [DATA_W-1:0] hold_data_q;
  logic [TAG_W-1:0]  hold_chan_q;
  logic              first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_data_q <= '0;
      hold_chan_q <= '0;
      first_q     <= 1'b1;
    end else begin
      if (eoc_i) begin
        hold_data_q <= result_i;
        hold_chan_q <= chan_i;
      end
      if (fs_fall_i) first_q <= 1'b0;
    end
  end

  // Tag off: data sits low so its MSB lands at bit DATA_W-1 (shorter delay line)
  always_comb begin
    if (first_q)       load_word_o = '1;
    else if (tag_en_i) load_word_o = {hold_data_q, hold_chan_q};
    else               load_word_o = {{TAG_W{1'b0}}, hold_data_q};
  end

  assign first_o = first_q;

  assert_capture_on_eoc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> (hold_data_q == $past(result_i)) && (hold_chan_q == $past(chan_i)));

  assert_first_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_fall_i |=> !first_q);
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
  parameter int DATA_W = adc_sdo_pkg::DATA_W,
  parameter int TAG_W  = adc_sdo_pkg::TAG_W,
  localparam int SH_W  = DATA_W + TAG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  adc_sdo_pkg::edges_t edg_i,
  input  logic                fs_ni,
  input  logic [SH_W-1:0]     load_word_i,
  input  logic                first_i,
  input  logic                tag_en_i,
  input  logic                chain_en_i,
  input  logic                chain_i,
  output logic                sdo_o,
  output logic                active_o
);
  logic [SH_W-1:0] shreg_q;
  logic            active_q, tag_q, chain_q, cdi_q;
  logic            load, shift_en, fill;

  assign load     = edg_i.fs_fall;
  assign shift_en = active_q & edg_i.sclk_fall & ~load;
  assign fill     = chain_q & cdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      active_q <= 1'b0;
      tag_q    <= 1'b0;
      chain_q  <= 1'b0;
      cdi_q    <= 1'b0;
    end else if (load) begin
      shreg_q  <= load_word_i;
      active_q <= 1'b1;
      tag_q    <= tag_en_i;
      chain_q  <= chain_en_i;
      cdi_q    <= 1'b0;
    end else if (fs_ni) begin
      active_q <= 1'b0;
    end else begin
      if (active_q && edg_i.sclk_rise) cdi_q <= chain_i;
      if (shift_en) shreg_q <= {shreg_q[SH_W-2:0], fill};
    end
  end

  // Tap point sets the chain delay: SH_W with tag, DATA_W without
  assign sdo_o    = active_q & (tag_q ? shreg_q[SH_W-1] : shreg_q[DATA_W-1]);
  assign active_o = active_q;

  assert_load_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> active_q && (shreg_q == $past(load_word_i)));

  assert_ones_first_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && first_i |=> shreg_q == '1);

  assert_close_on_fs_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_ni |=> !active_q);

  assert_hold_without_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !edg_i.sclk_fall && !load |=> $stable(shreg_q));
endmodule

// File: rtl/adc_result_serializer.sv
module adc_result_serializer #(
  parameter int DATA_W = adc_sdo_pkg::DATA_W,
  parameter int TAG_W  = adc_sdo_pkg::TAG_W,
  localparam int SH_W  = DATA_W + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [TAG_W-1:0]  chan_i,
  input  logic              tag_en_i,
  input  logic              chain_en_i,
  input  logic              fs_ni,
  input  logic              sclk_i,
  input  logic              chain_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  adc_sdo_pkg::edges_t edg;
  logic [SH_W-1:0]     load_word;
  logic                first;

  sdo_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fs_ni (fs_ni),
    .sclk_i(sclk_i),
    .edg_o (edg)
  );

  sdo_hold_reg #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eoc_i      (eoc_i),
    .result_i   (result_i),
    .chan_i     (chan_i),
    .fs_fall_i  (edg.fs_fall),
    .tag_en_i   (tag_en_i),
    .load_word_o(load_word),
    .first_o    (first)
  );

  sdo_shifter #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edg_i      (edg),
    .fs_ni      (fs_ni),
    .load_word_i(load_word),
    .first_i    (first),
    .tag_en_i   (tag_en_i),
    .chain_en_i (chain_en_i),
    .chain_i    (chain_i),
    .sdo_o      (sdo_o),
    .active_o   (sdo_oe_o)
  );
endmodule

// File: tb/sim_adc_result_serializer.sv
module sim_adc_result_serializer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        fs_n = 1'b1, sclk = 1'b0, tag_en = 1'b1;
  logic [2:0]  eoc = '0, chen = '0;
  logic [15:0] res [3];
  logic [2:0]  ch  [3];
  logic        sdo0, sdo1, sdo2, oe0, oe1, oe2;

  int    total = 0, bad = 0;
  string cur = "R6";
  logic  cap[$];
  bit    running = 1'b0;

  adc_result_serializer u0 (.clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc[0]), .result_i(res[0]),
    .chan_i(ch[0]), .tag_en_i(tag_en), .chain_en_i(chen[0]), .fs_ni(fs_n), .sclk_i(sclk),
    .chain_i(sdo1), .sdo_o(sdo0), .sdo_oe_o(oe0));
  adc_result_serializer u1 (.clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc[1]), .result_i(res[1]),
    .chan_i(ch[1]), .tag_en_i(tag_en), .chain_en_i(chen[1]), .fs_ni(fs_n), .sclk_i(sclk),
    .chain_i(sdo2), .sdo_o(sdo1), .sdo_oe_o(oe1));
  adc_result_serializer u2 (.clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc[2]), .result_i(res[2]),
    .chan_i(ch[2]), .tag_en_i(tag_en), .chain_en_i(chen[2]), .fs_ni(fs_n), .sclk_i(sclk),
    .chain_i(1'b0), .sdo_o(sdo2), .sdo_oe_o(oe2));

  // Behavioural reference for u0
  bit          m_first, m_oe, m_chain;
  logic [15:0] m_hd;
  logic [2:0]  m_hc;
  int          m_pos;
  logic        m_q[$];
  logic        fs_p, sc_p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_first = 1; m_oe = 0; m_chain = 0; m_hd = '0; m_hc = '0; m_pos = 0;
      m_q.delete(); fs_p = 1; sc_p = 0;
    end else begin
      if (fs_p && !fs_n) begin
        m_q.delete();
        for (int i = 15; i >= 0; i--) m_q.push_back(m_first ? 1'b1 : m_hd[i]);
        if (tag_en) for (int i = 2; i >= 0; i--) m_q.push_back(m_first ? 1'b1 : m_hc[i]);
        m_first = 0; m_pos = 0; m_oe = 1; m_chain = chen[0];
      end else if (fs_n) begin
        m_oe = 0;
      end else if (sc_p && !sclk && m_oe) begin
        m_pos++;
      end
      if (eoc[0]) begin m_hd = res[0]; m_hc = ch[0]; end
      fs_p = fs_n; sc_p = sclk;
    end
  end

  // Per-clock comparison
  always @(negedge clk) begin
    if (running && rst_n) begin
      logic exp_b;
      bit   skip;
      skip = 0; exp_b = 1'b0;
      if (m_oe) begin
        if (m_pos < m_q.size()) exp_b = m_q[m_pos];
        else if (m_chain) skip = 1;
      end
      total++;
      if (oe0 !== m_oe) begin
        bad++; $display("FAIL %s/R6 oe actual=%b expected=%b", cur, oe0, m_oe);
      end
      if (!skip) begin
        total++;
        if (sdo0 !== exp_b) begin
          bad++;
          $display("FAIL %s/R10 sdo pos=%0d actual=%b expected=%b", cur, m_pos, sdo0, exp_b);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] grab(input int off, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[62:0], cap[off+i]};
    return v;
  endfunction

  task automatic conv(input int d, input logic [15:0] v, input logic [2:0] c);
    @(negedge clk); eoc[d] = 1'b1; res[d] = v; ch[d] = c;
    @(negedge clk); eoc[d] = 1'b0;
  endtask

  task automatic frame(input int n, input bit coll, input bit mid,
                       input logic [15:0] v, input logic [2:0] c);
    cap.delete();
    @(negedge clk); fs_n = 1'b0;
    if (coll) begin eoc[0] = 1'b1; res[0] = v; ch[0] = c; end
    @(negedge clk); eoc[0] = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; @(negedge clk); cap.push_back(sdo0); @(negedge clk);
      sclk = 1'b0;
      if (mid && i == 2) begin eoc[0] = 1'b1; res[0] = v; ch[0] = c; end
      @(negedge clk); eoc[0] = 1'b0; @(negedge clk);
    end
    fs_n = 1'b1; repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++) begin res[d] = '0; ch[d] = '0; end
    repeat (3) @(negedge clk);
    chk("R6 reset oe", {62'd0, oe0, sdo0}, 64'd0);
    rst_n = 1'b1; running = 1'b1;
    repeat (2) @(negedge clk);

    cur = "R7";
    conv(0, 16'h1234, 3'd3);
    frame(22, 0, 0, 0, 0);
    chk("R7 ones frame", grab(0, 19), 64'h7FFFF);
    chk("R5 zero tail", grab(19, 3), 64'd0);

    cur = "R1";
    frame(22, 0, 0, 0, 0);
    chk("R1/R3 held data", grab(0, 16), 64'h1234);
    chk("R4 tag ch3", grab(16, 3), 64'd3);

    cur = "R2";
    conv(0, 16'hFFFF, 3'd5);
    frame(19, 0, 0, 0, 0);
    chk("R2 fall after eoc", grab(0, 19), {45'd0, 16'hFFFF, 3'd5});
    frame(19, 0, 1, 16'h00FF, 3'd6);
    chk("R2 fall before eoc", grab(0, 19), {45'd0, 16'hFFFF, 3'd5});
    frame(19, 0, 0, 0, 0);
    chk("R2 next frame new", grab(0, 19), {45'd0, 16'h00FF, 3'd6});
    frame(19, 1, 0, 16'hC001, 3'd2);
    chk("R2 same cycle old", grab(0, 19), {45'd0, 16'h00FF, 3'd6});
    frame(19, 0, 0, 0, 0);
    chk("R2 same cycle later", grab(0, 19), {45'd0, 16'hC001, 3'd2});

    cur = "R5";
    tag_en = 1'b0;
    conv(0, 16'h8000, 3'd7);
    frame(20, 0, 0, 0, 0);
    chk("R3 midscale", grab(0, 16), 64'h8000);
    chk("R5 no tag zeros", grab(16, 4), 64'd0);

    cur = "R8";
    conv(0, 16'hA000, 3'd1);
    frame(4, 0, 0, 0, 0);
    chk("R8 four msbs", grab(0, 4), 64'hA);
    frame(16, 0, 0, 0, 0);
    chk("R8 restart msb", grab(0, 16), 64'hA000);
    conv(0, 16'h0000, 3'd0);
    frame(16, 0, 0, 0, 0);
    chk("R3 zero code", grab(0, 16), 64'd0);

    cur = "R7";
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 oe in reset", {62'd0, oe0, sdo0}, 64'd0);
    rst_n = 1'b1;
    conv(0, 16'h5A5A, 3'd4);
    frame(18, 0, 0, 0, 0);
    chk("R7 ones after reset", grab(0, 18), {46'd0, 16'hFFFF, 2'b00});
    frame(16, 0, 0, 0, 0);
    chk("R7 held kept", grab(0, 16), 64'h5A5A);

    cur = "R9";
    tag_en = 1'b1; chen = 3'b011;
    conv(0, 16'hA5A5, 3'd1);
    conv(1, 16'h3C3C, 3'd2);
    conv(2, 16'h0FF0, 3'd6);
    frame(60, 0, 0, 0, 0);
    chk("R9 chain u0", grab(0, 19), {45'd0, 16'hA5A5, 3'd1});
    chk("R9 chain u1", grab(19, 19), {45'd0, 16'h3C3C, 3'd2});
    chk("R9 chain u2", grab(38, 19), {45'd0, 16'h0FF0, 3'd6});
    chk("R9 chain tail", grab(57, 3), 64'd0);

    tag_en = 1'b0;
    frame(50, 0, 0, 0, 0);
    chk("R9 chain no tag", grab(0, 48), {16'd0, 16'hA5A5, 16'h3C3C, 16'h0FF0});

    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule